// File: doc/BRIEF.md
# Transactional Dirty-Line Commit Tracker

This block sits next to one cache level and keeps the bookkeeping needed to make a transaction durable. Every line of the level has a persistence state (Clean, Pending or Persistent) and the ID of the transaction that owns it. The persistence state is held alongside any coherence state. When a store arrives, the tracker checks whether it is the first write of its transaction to that line. If it is, the line is marked Pending, tagged with the ID, and a record of the ID and line index goes into a metadata FIFO.

When software commits a transaction, the commit request names its ID. The tracker then walks the FIFO once. Every record owned by that ID becomes a writeback request to the next level and the record is removed. Records owned by other transactions go back into the FIFO in their original order. A written-back line becomes Persistent and stays resident. A small counter hands out a new transaction ID each time a transaction begins. An active-low asynchronous reset models loss of power: it clears the FIFO and returns every line to Clean.

The store port and the writeback port are valid/ready streams. A store is taken on a cycle where `st_valid` and `st_ready` are both high. `st_ready` drops when the FIFO is full and the store is a first write, when the store conflicts with another owner, and while a commit is requested or running. `wb_valid` and `wb_line` stay unchanged until `wb_ready` takes the request.

Top module: `txn_commit_tracker`

## Requirements
- R1: After reset `tx_id` is 0. `tx_id` is the ID granted to a `tx_begin` seen in that cycle, and it increases by 1 (modulo 2^ID_W) on the edge after each `tx_begin`.
- R2: `q_state` reports the state of line `q_line` as 2'b00 Clean, 2'b01 Pending or 2'b10 Persistent, and `q_txn` reports its owner ID. After reset every line is Clean with owner 0.
- R3: A store taken on a Clean or Persistent line is a first write. The line becomes Pending, its owner becomes `st_txn`, and one record is added to the FIFO.
- R4: A store to a line that is already Pending under the same ID is taken with no new record. This holds even when the FIFO is full.
- R5: While the FIFO holds DEPTH records, a first write sees `st_ready` low and the line state does not change.
- R6: A store to a line that is Pending under a different ID raises `st_conflict` and sees `st_ready` low. The owner and state of the line do not change.
- R7: A commit produces one writeback for each record of its ID, in FIFO order, with `wb_line` equal to the recorded line index. Each such line becomes Persistent. Records of other IDs are kept, in order, for later commits.
- R8: While `wb_valid` is high and `wb_ready` is low, `wb_valid` and `wb_line` hold steady. A record is removed only when its writeback is accepted.
- R9: `cm_done` is a one-cycle pulse that comes after all matching records are accepted. A commit with no matching record still produces the pulse.
- R10: `st_ready` is low while `cm_req` or `cm_busy` is high.
- R11: Reset empties the FIFO, so a commit issued right after reset produces no writeback.
- R12: A Persistent line accepts a first write from a later transaction and becomes Pending under the new owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-fail reset |
| tx_begin | input | 1 | A transaction begins and takes `tx_id` |
| tx_id | output | ID_W | Next transaction ID to grant |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store accepted this cycle when high with `st_valid` |
| st_line | input | LINE_W | Line index of the store |
| st_txn | input | ID_W | Transaction ID of the store |
| st_conflict | output | 1 | Store targets a line Pending under another ID |
| cm_req | input | 1 | Commit request pulse (ignored while busy) |
| cm_txn | input | ID_W | ID being committed |
| cm_busy | output | 1 | Commit walk in progress |
| cm_done | output | 1 | Commit complete pulse |
| wb_valid | output | 1 | Writeback request valid |
| wb_ready | input | 1 | Next level accepts the writeback |
| wb_line | output | LINE_W | Line index to write back |
| q_line | input | LINE_W | Line index to query |
| q_state | output | 2 | Persistence state of `q_line` |
| q_txn | output | ID_W | Owner ID of `q_line` |

## Verification
The bench uses NLINES=16, ID_W=4 and DEPTH=4. With a four-record FIFO, the full-stall case and the store to an owned line while the FIFO is full are both reached after a few stores. A commit can then cover a FIFO that mixes two owners, so the bench checks that matching records drain in order and that the others are kept. Writeback back-pressure is applied for several cycles to check that the request holds steady. The bench also covers a commit with no matching record and a reset in the middle of use.

// File: rtl/ctc_pkg.sv
package ctc_pkg;
  typedef enum logic [1:0] {
    PS_CLEAN = 2'b00,
    PS_PEND  = 2'b01,
    PS_PERS  = 2'b10
  } pstate_e;

  typedef enum logic {
    FL_IDLE = 1'b0,
    FL_RUN  = 1'b1
  } flush_e;
endpackage

// File: rtl/ctc_id_alloc.sv
module ctc_id_alloc #(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            grant,
  output logic [ID_W-1:0] next_id
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     next_id <= '0;
    else if (grant) next_id <= next_id + 1'b1;
  end
endmodule

// File: rtl/ctc_meta_fifo.sv
module ctc_meta_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic             full,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head = mem[rd_q];
  assign full = (count == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      count <= '0;
    end else begin
      if (push) wr_q <= bump(wr_q);
      if (pop)  rd_q <= bump(rd_q);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/ctc_line_table.sv
module ctc_line_table
  import ctc_pkg::*;
#(
  parameter int NLINES = 16,
  parameter int ID_W   = 4,
  parameter int LINE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_pend,
  input  logic [LINE_W-1:0] pend_line,
  input  logic [ID_W-1:0]   pend_txn,
  input  logic              set_pers,
  input  logic [LINE_W-1:0] pers_line,
  input  logic [LINE_W-1:0] rd_line,
  output logic [1:0]        rd_state,
  output logic [ID_W-1:0]   rd_txn,
  input  logic [LINE_W-1:0] q_line,
  output logic [1:0]        q_state,
  output logic [ID_W-1:0]   q_txn
);
  logic [1:0]      st_a  [NLINES];
  logic [ID_W-1:0] tag_a [NLINES];

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic [1:0]      st_r;
    logic [ID_W-1:0] tag_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_r  <= PS_CLEAN;
        tag_r <= '0;
      end else if (set_pend && pend_line == LINE_W'(i)) begin
        st_r  <= PS_PEND;
        tag_r <= pend_txn;
      end else if (set_pers && pers_line == LINE_W'(i)) begin
        st_r  <= PS_PERS;
      end
    end
    assign st_a[i]  = st_r;
    assign tag_a[i] = tag_r;
  end

  assign rd_state = st_a[rd_line];
  assign rd_txn   = tag_a[rd_line];
  assign q_state  = st_a[q_line];
  assign q_txn    = tag_a[q_line];
endmodule

// File: rtl/ctc_flush.sv
module ctc_flush
  import ctc_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int LINE_W = 4,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cm_req,
  input  logic [ID_W-1:0]   cm_txn,
  input  logic [CNT_W-1:0]  fifo_cnt,
  input  logic [ID_W-1:0]   head_txn,
  input  logic [LINE_W-1:0] head_line,
  input  logic              wb_ready,
  output logic              wb_valid,
  output logic [LINE_W-1:0] wb_line,
  output logic              pop,
  output logic              repush,
  output logic              busy,
  output logic              done
);
  flush_e           st_q;
  logic [CNT_W-1:0] left_q;
  logic [ID_W-1:0]  id_q;
  logic             active, match;

  assign busy   = (st_q == FL_RUN);
  assign active = busy && (left_q != '0);
  assign match  = (head_txn == id_q);
  assign wb_valid = active && match;
  assign wb_line  = head_line;
  assign pop      = active && (!match || wb_ready);
  assign repush   = active && !match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FL_IDLE;
      left_q <= '0;
      id_q   <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        FL_IDLE: if (cm_req) begin
          st_q   <= FL_RUN;
          left_q <= fifo_cnt;
          id_q   <= cm_txn;
        end
        FL_RUN: begin
          if (left_q == '0) begin
            st_q <= FL_IDLE;
            done <= 1'b1;
          end else if (pop) begin
            left_q <= left_q - 1'b1;
          end
        end
        default: st_q <= FL_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txn_commit_tracker.sv
module txn_commit_tracker
  import ctc_pkg::*;
#(
  parameter int NLINES = 16,
  parameter int ID_W   = 4,
  parameter int DEPTH  = 4,
  localparam int LINE_W = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_begin,
  output logic [ID_W-1:0]   tx_id,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [LINE_W-1:0] st_line,
  input  logic [ID_W-1:0]   st_txn,
  output logic              st_conflict,
  input  logic              cm_req,
  input  logic [ID_W-1:0]   cm_txn,
  output logic              cm_busy,
  output logic              cm_done,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [LINE_W-1:0] wb_line,
  input  logic [LINE_W-1:0] q_line,
  output logic [1:0]        q_state,
  output logic [ID_W-1:0]   q_txn
);
  localparam int REC_W = ID_W + LINE_W;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [1:0]       rd_state;
  logic [ID_W-1:0]  rd_txn;
  logic [REC_W-1:0] head, fifo_din;
  logic [CNT_W-1:0] fifo_cnt;
  logic             fifo_full, fifo_push, fifo_pop, repush;
  logic             pend_hit, own_hit, other_hit, take, first_wr;

  ctc_id_alloc #(.ID_W(ID_W)) u_ids (
    .clk(clk), .rst_n(rst_n), .grant(tx_begin), .next_id(tx_id)
  );

  assign pend_hit  = (rd_state == PS_PEND);
  assign own_hit   = pend_hit && (rd_txn == st_txn);
  assign other_hit = pend_hit && (rd_txn != st_txn);

  assign st_conflict = st_valid && other_hit;
  assign st_ready    = !cm_busy && !cm_req && !other_hit && (own_hit || !fifo_full);
  assign take        = st_valid && st_ready;
  assign first_wr    = take && !pend_hit;

  assign fifo_push = first_wr || repush;
  assign fifo_din  = repush ? head : {st_txn, st_line};

  ctc_line_table #(.NLINES(NLINES), .ID_W(ID_W), .LINE_W(LINE_W)) u_lines (
    .clk(clk), .rst_n(rst_n),
    .set_pend(first_wr), .pend_line(st_line), .pend_txn(st_txn),
    .set_pers(wb_valid && wb_ready), .pers_line(wb_line),
    .rd_line(st_line), .rd_state(rd_state), .rd_txn(rd_txn),
    .q_line(q_line), .q_state(q_state), .q_txn(q_txn)
  );

  ctc_meta_fifo #(.W(REC_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .din(fifo_din),
    .pop(fifo_pop), .head(head), .full(fifo_full), .count(fifo_cnt)
  );

  ctc_flush #(.ID_W(ID_W), .LINE_W(LINE_W), .CNT_W(CNT_W)) u_flush (
    .clk(clk), .rst_n(rst_n), .cm_req(cm_req), .cm_txn(cm_txn),
    .fifo_cnt(fifo_cnt), .head_txn(head[REC_W-1:LINE_W]),
    .head_line(head[LINE_W-1:0]), .wb_ready(wb_ready),
    .wb_valid(wb_valid), .wb_line(wb_line), .pop(fifo_pop),
    .repush(repush), .busy(cm_busy), .done(cm_done)
  );
endmodule

// File: rtl/ctc_checker.sv
module ctc_checker #(
  parameter int LINE_W = 4,
  parameter int ID_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_begin,
  input logic [ID_W-1:0]   tx_id,
  input logic              st_ready,
  input logic              st_conflict,
  input logic              cm_req,
  input logic              cm_busy,
  input logic              cm_done,
  input logic              wb_valid,
  input logic              wb_ready,
  input logic [LINE_W-1:0] wb_line
);
  p_id_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_begin |=> tx_id == ID_W'($past(tx_id) + 1'b1));

  p_conflict_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st_conflict |-> !st_ready);

  p_wb_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_line)));

  p_wb_in_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> cm_busy);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cm_done |=> !cm_done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cm_done |-> (!cm_busy && !wb_valid));

  p_commit_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_busy || cm_req) |-> !st_ready);
endmodule

bind txn_commit_tracker ctc_checker #(.LINE_W(LINE_W), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_begin(tx_begin), .tx_id(tx_id),
  .st_ready(st_ready), .st_conflict(st_conflict), .cm_req(cm_req),
  .cm_busy(cm_busy), .cm_done(cm_done), .wb_valid(wb_valid),
  .wb_ready(wb_ready), .wb_line(wb_line)
);

// File: tb/txn_commit_tracker_tb.sv
module txn_commit_tracker_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_begin = 1'b0;
  logic [3:0] tx_id;
  logic       st_valid = 1'b0;
  logic       st_ready;
  logic [3:0] st_line = '0;
  logic [3:0] st_txn = '0;
  logic       st_conflict;
  logic       cm_req = 1'b0;
  logic [3:0] cm_txn = '0;
  logic       cm_busy, cm_done, wb_valid;
  logic       wb_ready = 1'b0;
  logic [3:0] wb_line;
  logic [3:0] q_line = '0;
  logic [1:0] q_state;
  logic [3:0] q_txn;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [3:0] wb_seen [8];
  int wb_n = 0;

  always #5 clk = ~clk;

  txn_commit_tracker #(.NLINES(16), .ID_W(4), .DEPTH(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_begin(tx_begin), .tx_id(tx_id),
    .st_valid(st_valid), .st_ready(st_ready), .st_line(st_line),
    .st_txn(st_txn), .st_conflict(st_conflict), .cm_req(cm_req),
    .cm_txn(cm_txn), .cm_busy(cm_busy), .cm_done(cm_done),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_line(wb_line),
    .q_line(q_line), .q_state(q_state), .q_txn(q_txn)
  );

  // Vector: [15:12] line, [11:8] txn, [7] ready, [6] conflict, [5:4] state after, [3:0] owner after
  localparam logic [15:0] VEC [8] = '{
    16'h3191,  // R3 first write
    16'h3191,  // R4 same owner again
    16'h5292,  // R3
    16'h5152,  // R6 conflict
    16'h7191,  // R3
    16'h9292,  // R3 fills FIFO
    16'hB100,  // R5 full stall
    16'h3191   // R4 while full
  };

  function automatic string vreq(input int i);
    case (i)
      1, 7:    return "R4";
      3:       return "R6";
      6:       return "R5";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic query(input logic [3:0] ln, input logic [1:0] es,
                       input logic [3:0] et, input string req);
    q_line = ln;
    #1;
    check(q_state == es, req, "line state", q_state, es);
    check(q_txn == et, req, "line owner", q_txn, et);
  endtask

  task automatic do_store(input logic [3:0] ln, input logic [3:0] id,
                          input bit er, input bit ec, input string req);
    @(negedge clk);
    st_valid = 1'b1; st_line = ln; st_txn = id;
    #1;
    check(st_ready == er, req, "st_ready", st_ready, er);
    check(st_conflict == ec, req, "st_conflict", st_conflict, ec);
    @(posedge clk);
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic do_commit(input logic [3:0] id, input int stall, input bit probe);
    int hold;
    bit got, held;
    logic [3:0] prev;
    hold = stall; got = 1'b0; held = 1'b0; prev = '0; wb_n = 0;
    @(negedge clk);
    cm_txn = id; cm_req = 1'b1;
    #1;
    check(st_ready == 1'b0, "R10", "st_ready with cm_req", st_ready, 0);
    @(posedge clk);
    @(negedge clk);
    cm_req = 1'b0;
    if (probe) begin
      st_valid = 1'b1; st_line = 4'd12; st_txn = 4'd6;
      #1;
      check(st_ready == 1'b0, "R10", "st_ready while busy", st_ready, 0);
    end
    for (int k = 0; k < 60 && !got; k++) begin
      if (k > 0) @(negedge clk);
      if (cm_done) got = 1'b1;
      else begin
        if (wb_valid) begin
          if (held) check(wb_line == prev, "R8", "wb_line held", wb_line, prev);
          prev = wb_line;
          if (hold > 0) begin
            wb_ready = 1'b0; hold--; held = 1'b1;
          end else begin
            wb_ready = 1'b1; held = 1'b0; hold = stall;
            if (wb_n < 8) wb_seen[wb_n] = wb_line;
            wb_n++;
          end
        end else begin
          wb_ready = 1'b0;
          held = 1'b0;
        end
        @(posedge clk);
      end
    end
    st_valid = 1'b0; wb_ready = 1'b0;
    check(got, "R9", "cm_done seen", got, 1);
    @(negedge clk);
    check(!cm_done, "R9", "cm_done single pulse", cm_done, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2 reset values
    check(tx_id == 4'd0, "R1", "tx_id after reset", tx_id, 0);
    query(4'd0, 2'b00, 4'd0, "R2");
    query(4'd15, 2'b00, 4'd0, "R2");
    check(!cm_busy && !wb_valid && !cm_done, "R2", "idle after reset", cm_busy, 0);

    // R1 allocation
    for (int n = 1; n <= 2; n++) begin
      @(negedge clk); tx_begin = 1'b1;
      @(posedge clk);
      @(negedge clk); tx_begin = 1'b0;
      check(tx_id == 4'(n), "R1", "tx_id step", tx_id, n);
    end

    // Vector walk
    for (int i = 0; i < 8; i++) begin
      do_store(VEC[i][15:12], VEC[i][11:8], VEC[i][7], VEC[i][6], vreq(i));
      query(VEC[i][15:12], VEC[i][5:4], VEC[i][3:0], vreq(i));
    end

    // R7 commit of txn 1 with back-pressure (R8): expect lines 3 then 7
    do_commit(4'd1, 2, 1'b0);
    check(wb_n == 2, "R7", "writeback count", wb_n, 2);
    check(wb_seen[0] == 4'd3, "R7", "first writeback", wb_seen[0], 3);
    check(wb_seen[1] == 4'd7, "R7", "second writeback", wb_seen[1], 7);
    query(4'd3, 2'b10, 4'd1, "R7");
    query(4'd7, 2'b10, 4'd1, "R7");
    query(4'd5, 2'b01, 4'd2, "R7");

    // FIFO now holds two records; a new first write is accepted
    do_store(4'd11, 4'd3, 1'b1, 1'b0, "R3");
    query(4'd11, 2'b01, 4'd3, "R3");

    // R9 commit with no matching record, R10 probe during commit
    do_commit(4'd5, 0, 1'b1);
    check(wb_n == 0, "R9", "no writeback for absent id", wb_n, 0);
    query(4'd12, 2'b00, 4'd0, "R10");

    // R7 kept records drain in order
    do_commit(4'd2, 0, 1'b0);
    check(wb_n == 2, "R7", "kept records count", wb_n, 2);
    check(wb_seen[0] == 4'd5, "R7", "kept first", wb_seen[0], 5);
    check(wb_seen[1] == 4'd9, "R7", "kept second", wb_seen[1], 9);
    query(4'd9, 2'b10, 4'd2, "R7");

    // R12 persistent line rewritten by a later transaction
    do_store(4'd3, 4'd3, 1'b1, 1'b0, "R12");
    query(4'd3, 2'b01, 4'd3, "R12");

    // R11 power-fail reset empties FIFO
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    query(4'd11, 2'b00, 4'd0, "R11");
    check(tx_id == 4'd0, "R1", "tx_id after second reset", tx_id, 0);
    do_commit(4'd3, 0, 1'b0);
    check(wb_n == 0, "R11", "no writeback after reset", wb_n, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule